// File: doc/BRIEF.md
# Protection Fault Manager

This block takes four comparator flags from the analog protection circuits (over-current, over-temperature, under-voltage and over-voltage) and turns them into the digital responses of the driver. Each flag crosses into the clock domain through a synchronizer. It then passes a glitch filter, so that only a level held for several cycles is acted on. The filtered fault state drives four outputs:

- an active-low interrupt request, meant for an open-drain pad;
- a command that puts the power stage into high impedance;
- a one-cycle pulse that resets the configuration registers;
- an 8-bit status word plus a sticky summary fault flag, for the register file to present.

Each fault class follows its own recovery policy:

- An over-temperature indication clears as soon as its flag drops.
- An over-voltage indication follows its flag and leaves the configuration alone.
- An under-voltage event additionally wipes the configuration.
- An over-current event is held until software strobes a clear or the enable pin is taken low and then high again.

Top module: `prot_fault_mgr`

## Requirements
- R1: After reset `status_o` is 0x00, `fault_o` is 0, `irq_no` is 1, `hiz_o` is 0 and `reg_rst_o` is 0.
- R2: A raw flag affects the block only after it has been held for FILT_LEN (4) consecutive cycles. A shorter pulse changes no output. A held flag reaches the outputs on the sixth rising edge after it is applied, and its removal does too.
- R3: Status bit positions are over-temperature 7, over-voltage 5, under-voltage 4 and over-current 3. Bits 6 and 2..0 read 0. Raw flag inputs are indexed over-current 0, over-temperature 1, under-voltage 2, over-voltage 3.
- R4: While any status bit is set, `irq_no` is 0 and `hiz_o` is 1, from the same cycle the status bit appears.
- R5: The over-temperature bit follows the filtered flag and clears on its own.
- R6: When the filtered under-voltage flag rises, `reg_rst_o` pulses high for exactly one cycle, aligned with status bit 4. The bit clears with the flag.
- R7: The over-voltage bit follows the filtered flag and never raises `reg_rst_o`.
- R8: The over-current bit stays set after its flag drops. It clears on a `clr_i` strobe, or on a low-to-high transition of `en_i`, but only while the filtered flag is inactive. Holding `en_i` low does not clear it.
- R9: `fault_o` is set while any fault is active and stays set afterwards. It clears on a `clr_i` strobe given while no fault is active. A strobe given during an active fault is ignored.
- R10: `irq_no` returns to 1 only when no filtered fault is active and no over-current is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_flags_i | input | 4 | Asynchronous comparator flags {ov, uv, ot, oc} |
| en_i | input | 1 | Enable pin, asynchronous |
| clr_i | input | 1 | Synchronous status-clear strobe |
| irq_no | output | 1 | Interrupt request, active low |
| hiz_o | output | 1 | Output-stage high-impedance command |
| reg_rst_o | output | 1 | One-cycle configuration reset pulse |
| status_o | output | 8 | Fault status word |
| fault_o | output | 1 | Sticky summary fault flag |

## Verification
Every fault-driven output is due on the sixth rising edge after the raw flag changes: two synchronizer stages, then four filter counts. The bench drives on the falling edge and samples on falling edges. It checks that nothing has moved after five edges and that the result is present after six, so an extra or missing register stage is caught.

A `clr_i` strobe acts on the next edge and is checked one edge later. The enable-pin transition passes through a synchronizer, so the bench allows five edges before checking the over-current clear. Pulse lengths of one to three cycles are swept on every flag to confirm rejection.

// File: rtl/prot_fault_pkg.sv
package prot_fault_pkg;
  localparam int NUM_FAULTS = 4;
  localparam int STATUS_W   = 8;
  // raw flag indices
  localparam int F_OC = 0;
  localparam int F_OT = 1;
  localparam int F_UV = 2;
  localparam int F_OV = 3;
  // status bit positions, decoded by the register file
  localparam int SB_OT = 7;
  localparam int SB_OV = 5;
  localparam int SB_UV = 4;
  localparam int SB_OC = 3;
endpackage

// File: rtl/prot_flag_filter.sv
module prot_flag_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   flag_q;
  logic                   synced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {SYNC_STAGES{RST_VAL}};
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= RST_VAL;
    end else if (synced == flag_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
      cnt_q  <= '0;
      flag_q <= synced;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/prot_fault_policy.sv
module prot_fault_policy
  import prot_fault_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FAULTS-1:0] flt_i,
  input  logic                  clr_i,
  input  logic                  en_rise_i,
  output logic [STATUS_W-1:0]   status_o,
  output logic                  fault_o,
  output logic                  irq_no,
  output logic                  hiz_o,
  output logic                  reg_rst_o
);
  logic oc_lat_q, uv_d_q, sticky_q;
  logic any_f, oc_view;

  assign any_f   = |flt_i;
  assign oc_view = flt_i[F_OC] | oc_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_lat_q <= 1'b0;
      uv_d_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      uv_d_q <= flt_i[F_UV];
      if (flt_i[F_OC])            oc_lat_q <= 1'b1;
      else if (clr_i | en_rise_i) oc_lat_q <= 1'b0;
      if (any_f)      sticky_q <= 1'b1;
      else if (clr_i) sticky_q <= 1'b0;
    end
  end

  always_comb begin
    status_o        = '0;
    status_o[SB_OT] = flt_i[F_OT];
    status_o[SB_OV] = flt_i[F_OV];
    status_o[SB_UV] = flt_i[F_UV];
    status_o[SB_OC] = oc_view;
  end

  assign fault_o   = sticky_q | any_f;
  assign irq_no    = ~(any_f | oc_lat_q);
  assign hiz_o     = any_f | oc_lat_q;
  assign reg_rst_o = flt_i[F_UV] & ~uv_d_q;
endmodule

// File: rtl/prot_fault_mgr.sv
module prot_fault_mgr
  import prot_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FAULTS-1:0] raw_flags_i,
  input  logic                  en_i,
  input  logic                  clr_i,
  output logic                  irq_no,
  output logic                  hiz_o,
  output logic                  reg_rst_o,
  output logic [STATUS_W-1:0]   status_o,
  output logic                  fault_o
);
  logic [NUM_FAULTS-1:0] flt;
  logic                  en_s, en_d_q, en_rise;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_flt
    prot_flag_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RST_VAL    (1'b0)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_flags_i[g]),
      .flag_o(flt[g])
    );
  end

  // enable pin: synchronize only
  prot_flag_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (1),
    .RST_VAL    (1'b1)
  ) u_en_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (en_i),
    .flag_o(en_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_d_q <= 1'b1;
    else         en_d_q <= en_s;
  end

  assign en_rise = en_s & ~en_d_q;

  prot_fault_policy u_policy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flt_i    (flt),
    .clr_i    (clr_i),
    .en_rise_i(en_rise),
    .status_o (status_o),
    .fault_o  (fault_o),
    .irq_no   (irq_no),
    .hiz_o    (hiz_o),
    .reg_rst_o(reg_rst_o)
  );
endmodule

// File: rtl/prot_fault_mgr_chk.sv
module prot_fault_mgr_chk
  import prot_fault_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_FAULTS-1:0] raw_flags_i,
  input logic                  en_i,
  input logic                  clr_i,
  input logic                  irq_no,
  input logic                  hiz_o,
  input logic                  reg_rst_o,
  input logic [STATUS_W-1:0]   status_o,
  input logic                  fault_o
);
  logic any_st;
  assign any_st = status_o[SB_OT] | status_o[SB_OV] | status_o[SB_UV] | status_o[SB_OC];

  a_r4_fault_drives_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_st |-> (!irq_no && hiz_o));

  a_r10_irq_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no |-> !any_st);

  a_r6_rst_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> !reg_rst_o);

  a_r6_rst_with_uv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |-> status_o[SB_UV]);

  a_r9_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i) |=> fault_o);

  a_r9_summary_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_st |-> fault_o);
endmodule

bind prot_fault_mgr prot_fault_mgr_chk u_chk (.*);

// File: tb/prot_fault_mgr_bench.sv
module prot_fault_mgr_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] raw_flags_i;
  logic       en_i, clr_i;
  logic       irq_no, hiz_o, reg_rst_o, fault_o;
  logic [7:0] status_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  prot_fault_mgr u_prot_fault_mgr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_flags_i(raw_flags_i),
    .en_i       (en_i),
    .clr_i      (clr_i),
    .irq_no     (irq_no),
    .hiz_o      (hiz_o),
    .reg_rst_o  (reg_rst_o),
    .status_o   (status_o),
    .fault_o    (fault_o)
  );

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_clr();
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
  endtask

  // status bit position per raw index (R3)
  function automatic int bitpos(input int i);
    case (i)
      0: return 3;
      1: return 7;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic string recov_req(input int i);
    case (i)
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    rst_ni = 1'b0; raw_flags_i = '0; en_i = 1'b1; clr_i = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 status", status_o, 8'h00);
    chk("R1 fault", fault_o, 1'b0);
    chk("R1 irq", irq_no, 1'b1);
    chk("R1 hiz", hiz_o, 1'b0);
    chk("R1 reg_rst", reg_rst_o, 1'b0);

    for (int i = 0; i < 4; i++) begin
      // R2 short pulses rejected
      for (int len = 1; len <= 3; len++) begin
        raw_flags_i[i] = 1'b1;
        step(len);
        raw_flags_i[i] = 1'b0;
        step(8);
        chk("R2 glitch status", status_o, 8'h00);
        chk("R2 glitch irq", irq_no, 1'b1);
        chk("R2 glitch fault", fault_o, 1'b0);
      end
      raw_flags_i[i] = 1'b1;
      step(5);
      chk("R2 not yet", status_o, 8'h00);
      step(1);
      chk("R3 bit position", status_o, 32'(1 << bitpos(i)));
      chk("R4 irq low", irq_no, 1'b0);
      chk("R4 hiz high", hiz_o, 1'b1);
      chk("R9 fault set", fault_o, 1'b1);
      chk((i == 2) ? "R6 reg_rst" : "R7 no reg_rst", reg_rst_o, (i == 2) ? 1'b1 : 1'b0);
      step(1);
      chk("R6 pulse width", reg_rst_o, 1'b0);
      step(4);
      raw_flags_i[i] = 1'b0;
      step(6);
      if (i == 0) begin
        chk("R8 oc held", status_o, 8'h08);
        chk("R10 irq held", irq_no, 1'b0);
        pulse_clr();
        chk("R8 oc cleared", status_o, 8'h00);
        chk("R10 irq released", irq_no, 1'b1);
        chk("R9 fault cleared", fault_o, 1'b0);
      end else begin
        chk(recov_req(i), status_o, 8'h00);
        chk("R10 irq released", irq_no, 1'b1);
        chk("R4 hiz released", hiz_o, 1'b0);
        chk("R9 fault sticky", fault_o, 1'b1);
        pulse_clr();
        chk("R9 fault cleared", fault_o, 1'b0);
      end
    end

    // R8 clear ignored while active, then enable cycling
    raw_flags_i[0] = 1'b1;
    step(6);
    pulse_clr();
    chk("R8 clr while active", status_o, 8'h08);
    chk("R9 clr while active", fault_o, 1'b1);
    raw_flags_i[0] = 1'b0;
    step(8);
    chk("R8 still latched", status_o, 8'h08);
    en_i = 1'b0;
    step(6);
    chk("R8 en low no clear", status_o, 8'h08);
    en_i = 1'b1;
    step(5);
    chk("R8 en cycle clear", status_o, 8'h00);
    chk("R10 irq after en", irq_no, 1'b1);
    chk("R9 sticky after en", fault_o, 1'b1);
    pulse_clr();
    chk("R9 cleared", fault_o, 0);

    // R10 latched oc keeps irq low after ot recovers
    raw_flags_i = 4'b0011;
    step(6);
    chk("R3 two faults", status_o, 8'h88);
    raw_flags_i = 4'b0000;
    step(6);
    chk("R10 oc only", status_o, 8'h08);
    chk("R10 irq held by latch", irq_no, 1'b0);
    pulse_clr();
    chk("R10 irq released", irq_no, 1'b1);

    // all four together
    raw_flags_i = 4'b1111;
    step(6);
    chk("R3 all", status_o, 8'hB8);
    chk("R6 reg_rst all", reg_rst_o, 1'b1);
    raw_flags_i = 4'b0000;
    step(6);
    chk("R5 R7 recover", status_o, 8'h08);
    pulse_clr();
    chk("R9 final", fault_o, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule